// File: doc/BRIEF.md
# Receive DMA Context Control Register Bank

This block holds the control and status words for a set of receive DMA contexts, four by default. Software never writes a word directly. Each context has two write addresses. A write to the first address turns on every bit that is 1 in the write data. A write to the second address turns off every bit that is 1 in the write data. Bits written as 0 keep their value. A read at either address returns the current word of that context.

Each word holds three receive-mode bits, a run bit that software owns and an active bit that hardware owns. The mode bits go straight to the DMA engine. The engine reports back a per-context idle flag, and the bank uses it to drop the active bit.

The mode bits are write-protected while a context is running or still draining. Multi-channel reception needs buffer-fill packing, and the bank keeps the two bits consistent. The register port is single-cycle: a write takes effect at the next clock edge, and the read data is combinational from the address.

Top module: `rxctx_ctrl_bank`

## Requirements
- R1: After a synchronous active-low reset, every context word reads 0 and every per-context output is 0.
- R2: Context n (0 to 3) uses write-to-set address 0x400 + 32*n and write-to-clear address 0x404 + 32*n. A read at either of these addresses returns that context's word.
- R3: A write to the set address sets each bit that is 1 in the data. A write to the clear address clears each bit that is 1 in the data. Data bits that are 0 leave the corresponding bits unchanged.
- R4: Only these bits are implemented: 31 (buffer-fill packing), 30 (keep the 4-byte packet header), 28 (multi-channel), 15 (run) and 10 (active). All other bits read 0, and writes to them have no effect. Software writes to bit 10 are ignored.
- R5: The active bit becomes 1 at the clock edge after the one at which run is seen as 1.
- R6: Once run is 0, the active bit stays 1 until the first clock edge at which the context's engine_idle input is 1. It becomes 0 at that edge.
- R7: While run or active is 1, set and clear writes to bits 31, 30 and 28 are ignored. Run and active are judged by their values before the write.
- R8: A set of bit 28 also sets bit 31.
- R9: A clear of bit 31 is ignored while bit 28 is 1.
- R10: A read at any address that belongs to no context returns 0. A write to such an address changes no context.
- R11: The ctx_fill, ctx_hdr, ctx_multi, ctx_run and ctx_active outputs carry, for each context n at index n, the current bits 31, 30, 28, 15 and 10 of that context's word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 12 | Register byte address |
| wr_en | input | 1 | Write strobe, one write per asserted cycle |
| wr_data | input | 32 | Write data, used as a bit mask for set or clear |
| rd_data | output | 32 | Word of the addressed context; 0 when no context is addressed |
| engine_idle | input | 4 | Per-context idle flag from the DMA engine |
| ctx_fill | output | 4 | Per-context buffer-fill packing mode |
| ctx_hdr | output | 4 | Per-context keep-header mode |
| ctx_multi | output | 4 | Per-context multi-channel mode |
| ctx_run | output | 4 | Per-context run bit |
| ctx_active | output | 4 | Per-context active bit |

## Verification
Some invariants are checked by assertions on every clock cycle:
- multi-channel never stands without buffer-fill;
- the mode bits hold still in any cycle that starts locked;
- run is always followed by active one edge later;
- active only falls after a cycle with run low and idle high;
- no address hits two contexts at once.

Other behaviour can only be shown by the bench's scenarios. These are:
- the exact read values through both aliases;
- the zero reads of reserved bits and unmapped offsets;
- ignored writes to the active bit;
- the independence of neighbouring contexts;
- the delay with which active appears and drains at the ports.

// File: rtl/rxctx_pkg.sv
// Shared positions and types for the receive context control bank.
// Assumes a 32-bit register word; bit positions are visible to software.
package rxctx_pkg;
    localparam int REG_W      = 32;
    localparam int BIT_FILL   = 31;
    localparam int BIT_HDR    = 30;
    localparam int BIT_MULTI  = 28;
    localparam int BIT_RUN    = 15;
    localparam int BIT_ACTIVE = 10;

    typedef struct packed {
        logic fill;
        logic hdr;
        logic multi;
        logic run;
        logic active;
    } ctx_state_t;

    // Build the software-visible word; all unimplemented bits are 0.
    function automatic logic [REG_W-1:0] pack_word(input ctx_state_t s);
        logic [REG_W-1:0] w;
        w             = '0;
        w[BIT_FILL]   = s.fill;
        w[BIT_HDR]    = s.hdr;
        w[BIT_MULTI]  = s.multi;
        w[BIT_RUN]    = s.run;
        w[BIT_ACTIVE] = s.active;
        return w;
    endfunction
endpackage

// File: rtl/rxctx_addr_decode.sv
// Address decoder: turns the byte address into per-context set, clear and
// read selects. Assumes STRIDE > CLR_OFS so that aliases never overlap.
module rxctx_addr_decode #(
    parameter int NUM_CTX = 4,
    parameter int ADDR_W  = 12,
    parameter int BASE    = 'h400,
    parameter int STRIDE  = 32,
    parameter int CLR_OFS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               wr_en,
    output logic [NUM_CTX-1:0] set_stb,
    output logic [NUM_CTX-1:0] clr_stb,
    output logic [NUM_CTX-1:0] rd_sel
);
    logic [NUM_CTX-1:0] set_hit;
    logic [NUM_CTX-1:0] clr_hit;

    for (genvar n = 0; n < NUM_CTX; n++) begin : g_ctx
        localparam logic [ADDR_W-1:0] SET_ADDR = ADDR_W'(BASE + n*STRIDE);
        localparam logic [ADDR_W-1:0] CLR_ADDR = ADDR_W'(BASE + n*STRIDE + CLR_OFS);
        // Compare the address against both aliases of this context.
        always_comb begin
            set_hit[n] = (addr == SET_ADDR);
            clr_hit[n] = (addr == CLR_ADDR);
        end
    end

    // Qualify hits with the write strobe and merge them into read selects.
    always_comb begin
        set_stb = set_hit & {NUM_CTX{wr_en}};
        clr_stb = clr_hit & {NUM_CTX{wr_en}};
        rd_sel  = set_hit | clr_hit;
    end

    // R2: an address selects at most one context.
    assert_single_context_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_sel));
endmodule

// File: rtl/rxctx_ctx_reg.sv
// One context's control word: applies set and clear writes, enforces the
// mode lock and the multi-channel dependency, and tracks the active bit.
// Assumes set_stb and clr_stb are never both high.
module rxctx_ctx_reg
    import rxctx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_stb,
    input  logic             clr_stb,
    input  logic [REG_W-1:0] wr_data,
    input  logic             engine_idle,
    output ctx_state_t       state
);
    ctx_state_t q, nxt;
    logic       locked;

    // Lock the mode bits while the context runs or still drains.
    always_comb locked = q.run | q.active;

    // Next-state rules for the software bits and the active bit.
    always_comb begin
        nxt = q;
        if (set_stb) begin
            if (wr_data[BIT_RUN]) nxt.run = 1'b1;
            if (!locked) begin
                if (wr_data[BIT_FILL]) nxt.fill = 1'b1;
                if (wr_data[BIT_HDR])  nxt.hdr  = 1'b1;
                if (wr_data[BIT_MULTI]) begin
                    nxt.multi = 1'b1;
                    nxt.fill  = 1'b1;
                end
            end
        end
        if (clr_stb) begin
            if (wr_data[BIT_RUN]) nxt.run = 1'b0;
            if (!locked) begin
                if (wr_data[BIT_HDR])              nxt.hdr   = 1'b0;
                if (wr_data[BIT_MULTI])            nxt.multi = 1'b0;
                if (wr_data[BIT_FILL] && !q.multi) nxt.fill  = 1'b0;
            end
        end
        if (q.run)            nxt.active = 1'b1;
        else if (engine_idle) nxt.active = 1'b0;
    end

    // Register the word with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end

    always_comb state = q;

    // R7: mode bits do not move across a cycle that began locked.
    assert_mode_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.run || q.active) |=> $stable({q.fill, q.hdr, q.multi}));

    // R8 and R9: multi-channel never stands without buffer-fill.
    assert_multi_needs_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
        q.multi |-> q.fill);

    // R5: a running context is active one edge later.
    assert_active_follows_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        q.run |=> q.active);

    // R6: active only drops after a cycle with run low and the engine idle.
    assert_active_drain_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.active) |-> $past(!q.run && engine_idle));
endmodule

// File: rtl/rxctx_read_mux.sv
// Read path: returns the packed word of the selected context, or 0 when
// no context is selected. Assumes at most one select is high.
module rxctx_read_mux
    import rxctx_pkg::*;
#(
    parameter int NUM_CTX = 4
) (
    input  ctx_state_t       states [NUM_CTX],
    input  logic [NUM_CTX-1:0] rd_sel,
    output logic [REG_W-1:0] rd_data
);
    // OR together the masked words of all contexts.
    always_comb begin
        rd_data = '0;
        for (int n = 0; n < NUM_CTX; n++) begin
            if (rd_sel[n]) rd_data = rd_data | pack_word(states[n]);
        end
    end
endmodule

// File: rtl/rxctx_ctrl_bank.sv
// Top of the receive context control bank: decoder, one control word per
// context and the read multiplexer. Assumes a single-cycle register port;
// reads are combinational, writes land at the next clock edge.
module rxctx_ctrl_bank
    import rxctx_pkg::*;
#(
    parameter int NUM_CTX = 4,
    parameter int ADDR_W  = 12,
    parameter int BASE    = 'h400,
    parameter int STRIDE  = 32,
    parameter int CLR_OFS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               wr_en,
    input  logic [REG_W-1:0]   wr_data,
    output logic [REG_W-1:0]   rd_data,
    input  logic [NUM_CTX-1:0] engine_idle,
    output logic [NUM_CTX-1:0] ctx_fill,
    output logic [NUM_CTX-1:0] ctx_hdr,
    output logic [NUM_CTX-1:0] ctx_multi,
    output logic [NUM_CTX-1:0] ctx_run,
    output logic [NUM_CTX-1:0] ctx_active
);
    logic [NUM_CTX-1:0] set_stb;
    logic [NUM_CTX-1:0] clr_stb;
    logic [NUM_CTX-1:0] rd_sel;
    ctx_state_t         states [NUM_CTX];

    rxctx_addr_decode #(
        .NUM_CTX(NUM_CTX), .ADDR_W(ADDR_W), .BASE(BASE),
        .STRIDE(STRIDE), .CLR_OFS(CLR_OFS)
    ) u_decode (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .set_stb(set_stb), .clr_stb(clr_stb), .rd_sel(rd_sel)
    );

    for (genvar n = 0; n < NUM_CTX; n++) begin : g_ctx
        rxctx_ctx_reg u_ctx (
            .clk(clk), .rst_n(rst_n),
            .set_stb(set_stb[n]), .clr_stb(clr_stb[n]),
            .wr_data(wr_data), .engine_idle(engine_idle[n]),
            .state(states[n])
        );
        // Fan the word's fields out to the engine-facing outputs.
        always_comb begin
            ctx_fill[n]   = states[n].fill;
            ctx_hdr[n]    = states[n].hdr;
            ctx_multi[n]  = states[n].multi;
            ctx_run[n]    = states[n].run;
            ctx_active[n] = states[n].active;
        end
    end

    rxctx_read_mux #(.NUM_CTX(NUM_CTX)) u_rdmux (
        .states(states), .rd_sel(rd_sel), .rd_data(rd_data)
    );
endmodule

// File: tb/test_rxctx_ctrl_bank.sv
// Directed bench for the receive context control bank.
module test_rxctx_ctrl_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [3:0]  engine_idle = 4'hF;
    logic [3:0]  ctx_fill, ctx_hdr, ctx_multi, ctx_run, ctx_active;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rxctx_ctrl_bank i_rxctx_ctrl_bank (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .engine_idle(engine_idle),
        .ctx_fill(ctx_fill), .ctx_hdr(ctx_hdr), .ctx_multi(ctx_multi),
        .ctx_run(ctx_run), .ctx_active(ctx_active)
    );

    function automatic logic [11:0] set_a(int n); return 12'(32'h400 + 32*n); endfunction
    function automatic logic [11:0] clr_a(int n); return 12'(32'h404 + 32*n); endfunction

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rd_data;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int n = 0; n < 4; n++) begin
            rd(set_a(n), v); chk("R1 reset word", v, 32'h0);
        end
        chk("R1 reset outputs", {12'h0, ctx_fill, ctx_hdr, ctx_multi, ctx_run, ctx_active}, 32'h0);
    endtask

    task automatic t_set_clear();
        logic [31:0] v;
        wr(set_a(1), 32'h4000_0000);
        rd(set_a(1), v); chk("R3 set hdr", v, 32'h4000_0000);
        rd(clr_a(1), v); chk("R2 read via clear alias", v, 32'h4000_0000);
        wr(set_a(1), 32'h8000_0000);
        rd(set_a(1), v); chk("R3 zero bits unchanged", v, 32'hC000_0000);
        chk("R11 fill/hdr outputs", {28'h0, ctx_fill[1], ctx_hdr[1], ctx_multi[1], 1'b0}, 32'hC);
        wr(clr_a(1), 32'h4000_0000);
        rd(set_a(1), v); chk("R3 clear hdr only", v, 32'h8000_0000);
        rd(set_a(0), v); chk("R2 neighbour untouched", v, 32'h0);
        wr(clr_a(1), 32'h8000_0000);
        rd(set_a(1), v); chk("R3 clear fill", v, 32'h0);
    endtask

    task automatic t_reserved();
        logic [31:0] v;
        wr(set_a(0), 32'h0000_0400);
        rd(set_a(0), v); chk("R4 active not writable", v, 32'h0);
        chk("R4 active output", {31'h0, ctx_active[0]}, 32'h0);
        wr(set_a(0), 32'h2FFF_7BFF);
        rd(set_a(0), v); chk("R4 reserved bits read 0", v, 32'h0);
    endtask

    task automatic t_run_lock();
        logic [31:0] v;
        wr(set_a(2), 32'hFFFF_FFFF);
        chk("R5 run set, active not yet", {30'h0, ctx_run[2], ctx_active[2]}, 32'h2);
        @(negedge clk);
        chk("R5 active one edge later", {31'h0, ctx_active[2]}, 32'h1);
        rd(clr_a(2), v); chk("R4 all-ones set word", v, 32'hD000_8400);
        wr(clr_a(2), 32'hD000_0000);
        rd(set_a(2), v); chk("R7 clear ignored while running", v, 32'hD000_8400);
        engine_idle[2] = 1'b0;
        wr(clr_a(2), 32'h0000_8000);
        rd(set_a(2), v); chk("R6 active held while busy", v, 32'hD000_0400);
        wr(clr_a(2), 32'hD000_0000);
        rd(set_a(2), v); chk("R7 clear ignored while active", v, 32'hD000_0400);
        @(negedge clk); engine_idle[2] = 1'b1;
        @(negedge clk);
        chk("R6 active drops after idle", {31'h0, ctx_active[2]}, 32'h0);
        wr(clr_a(2), 32'h5000_0000);
        rd(set_a(2), v); chk("R7 unlocked clear applies", v, 32'h8000_0000);
        wr(clr_a(2), 32'h8000_0000);
        rd(set_a(2), v); chk("R7 fill cleared", v, 32'h0);
    endtask

    task automatic t_multi();
        logic [31:0] v;
        wr(set_a(3), 32'h1000_0000);
        rd(set_a(3), v); chk("R8 multi forces fill", v, 32'h9000_0000);
        chk("R11 multi output", {31'h0, ctx_multi[3]}, 32'h1);
        wr(clr_a(3), 32'h8000_0000);
        rd(set_a(3), v); chk("R9 fill clear ignored", v, 32'h9000_0000);
        wr(clr_a(3), 32'h1000_0000);
        rd(set_a(3), v); chk("R9 multi cleared alone", v, 32'h8000_0000);
        wr(clr_a(3), 32'h8000_0000);
        rd(set_a(3), v); chk("R9 fill now clearable", v, 32'h0);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        wr(set_a(0), 32'h4000_0000);
        rd(12'h408, v); chk("R10 gap offset reads 0", v, 32'h0);
        rd(12'h3FC, v); chk("R10 below base reads 0", v, 32'h0);
        rd(12'h480, v); chk("R10 past last context reads 0", v, 32'h0);
        wr(12'h408, 32'hFFFF_FFFF);
        wr(12'h480, 32'hFFFF_FFFF);
        rd(set_a(0), v); chk("R10 stray writes ignored", v, 32'h4000_0000);
        rd(set_a(1), v); chk("R10 context 1 untouched", v, 32'h0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_set_clear();
        t_reserved();
        t_run_lock();
        t_multi();
        t_unmapped();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog all requirements actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule